// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This block is a synchronous model of the write side of a byte-wide nonvolatile memory. It samples active-low chip-enable, write-enable and output-enable strobes together with an address bus and an 8-bit data bus. Single bytes or bursts of up to 64 bytes are gathered into a page buffer. Once the bus has been quiet for long enough, the buffer is committed to a behavioural memory array during an internal program phase of fixed length. The address width is a parameter. Its default of 11 bits gives 2048 locations, and a value of 13 gives the full 8192-location part.

A burst has no closing command. It ends when the bus stays inactive for a set time. The first byte of the burst fixes the page, and the address and data of each byte are taken on opposite edges of the write strobe. A busy output tells the surrounding status logic when the block will not accept writes. Reads return the array contents with one cycle of latency. All time windows are counts of clock cycles, set by parameters, so the model simulates quickly.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy` is low and `dout` is zero.
- R2: A write strobe exists only while `ce_n` and `we_n` are both low and `oe_n` is high. A cycle with `oe_n` low writes nothing and leaves `busy` low.
- R3: A byte's address is taken in the first cycle of its strobe. Its data is taken in the cycle in which the strobe ends. Bus changes in between have no effect.
- R4: The page, `addr[ADDR_W-1:6]`, comes from the first byte of a burst. Later bytes in the same burst use only `addr[5:0]` and land in that page.
- R5: A further byte joins the burst only if its strobe starts within LOAD_CYC cycles of the previous accepted strobe start. A later strobe, arriving before the program phase has finished, is dropped.
- R6: The program phase starts IDLE_CYC cycles after the last data capture. It updates only the page entries loaded in the burst. All other locations keep their contents, and a full 64-byte page is written completely.
- R7: `busy` rises in the cycle after the first accepted strobe start. It stays high through the quiet time and a program phase of PROG_CYC cycles, then falls.
- R8: Write strobes during the program phase are ignored.
- R9: When one offset is loaded more than once in a burst, the last data wins.
- R10: With `ce_n` low, `oe_n` low and `we_n` high, `dout` shows the array byte at `addr` one cycle later. Otherwise `dout` is zero.
- R11: A write issued after `busy` has fallen starts a new burst, with its page taken from its own address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; upper bits select the page, low 6 bits the byte within the page |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, registered |
| busy | output | 1 | High from the first accepted byte until the program phase completes |

## Verification
The assertions assume that every strobe lasts at least one cycle and ends before the next one begins. They also assume that LOAD_CYC is less than IDLE_CYC and that PROG_CYC is at least 64, so a window closes before the commit and every page entry gets a program slot. The bench respects all of this. Each stimulus task holds a strobe for two cycles and separates strobes by at least one idle cycle. Every bus change is applied on the falling clock edge. The parameters keep their default values throughout.

// File: rtl/eepw_pkg.sv
// Package: types shared by the page-write sequencer modules.
// Assumes nothing beyond standard SystemVerilog.
package eepw_pkg;

    // Sequencer phases.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // no burst open
        ST_LOAD = 2'd1,  // burst open, load window running
        ST_HOLD = 2'd2,  // load window closed, waiting for quiet time
        ST_PROG = 2'd3   // internal program phase
    } eepw_state_e;

endpackage

// File: rtl/eepw_strobe.sv
// Module: strobe edge detector.
// Combines the three active-low enables into a write strobe and reports its start
// and end as single-cycle pulses. It also decodes a read cycle.
// Assumes the enables are already synchronous to clk.
module eepw_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_start_o,
    output logic wr_end_o,
    output logic rd_en_o
);

    logic stb;
    logic stb_q;

    // A write needs chip and write enable low with output enable high.
    assign stb = !ce_n && !we_n && oe_n;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb;
    end

    assign wr_start_o = stb && !stb_q;
    assign wr_end_o   = !stb && stb_q;
    assign rd_en_o    = !ce_n && !oe_n && we_n;

endmodule

// File: rtl/eepw_page_buf.sv
// Module: page buffer.
// Holds one page of bytes with a loaded flag for each entry. Writes are indexed
// by the byte offset. A clear drops all loaded flags.
// Assumes a write and a clear never arrive in the same cycle.
module eepw_page_buf #(
    parameter int PAGE_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [OFF_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              clr_i,
    input  logic [OFF_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);

    logic [DATA_W-1:0] data_q [PAGE_BYTES];
    logic              vld_q  [PAGE_BYTES];

    // Store incoming bytes and track which entries have been loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                data_q[i] <= '0;
                vld_q[i]  <= 1'b0;
            end
        end else begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (clr_i) begin
                    vld_q[i] <= 1'b0;
                end else if (wr_en_i && (wr_idx_i == OFF_W'(i))) begin
                    data_q[i] <= wr_data_i;
                    vld_q[i]  <= 1'b1;
                end
            end
        end
    end

    assign rd_data_o  = data_q[rd_idx_i];
    assign rd_valid_o = vld_q[rd_idx_i];

endmodule

// File: rtl/eepw_array.sv
// Module: behavioural memory array.
// One write port and one registered read port. The read data is zero whenever no
// read is requested.
// Assumes the array contents need no reset, as in a nonvolatile store.
module eepw_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Program one byte into the array.
    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    // Register read data, returning zero outside a read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= '0;
        else if (re_i) rdata_o <= mem_q[raddr_i];
        else           rdata_o <= '0;
    end

    // R10: the output returns to zero after a cycle without a read.
    a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !re_i |=> (rdata_o == '0));

endmodule

// File: rtl/eepw_ctrl.sv
// Module: burst and program sequencer.
// Opens a burst on an accepted strobe start and fixes the page there. It takes
// byte offsets on strobe starts and tells the buffer when to store data on strobe
// ends. It closes the load window and commits after the quiet time, then walks the
// page, one offset per cycle, during a program phase of fixed length.
// Assumes LOAD_CYC < IDLE_CYC and PROG_CYC >= PAGE_BYTES.
module eepw_ctrl
    import eepw_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 64,
    parameter int LOAD_CYC   = 30,
    parameter int IDLE_CYC   = 100,
    parameter int PROG_CYC   = 200,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - OFF_W,
    localparam int LCW       = $clog2(LOAD_CYC + 1),
    localparam int ICW       = $clog2(IDLE_CYC + 1),
    localparam int PCW       = $clog2(PROG_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start_i,
    input  logic              wr_end_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              buf_valid_i,
    output logic              buf_we_o,
    output logic [OFF_W-1:0]  buf_widx_o,
    output logic              buf_clr_o,
    output logic [OFF_W-1:0]  buf_ridx_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_waddr_o,
    output logic              busy_o
);

    eepw_state_e      state_q;
    logic [PG_W-1:0]  page_q;
    logic [OFF_W-1:0] off_q;
    logic             pend_q;
    logic [LCW-1:0]   load_cnt_q;
    logic [ICW-1:0]   idle_cnt_q;
    logic [PCW-1:0]   prog_cnt_q;

    logic in_burst;
    logic commit;
    logic accept;
    logic capture;
    logic prog_last;

    // Decode the events that move the sequencer.
    always_comb begin
        in_burst  = (state_q == ST_LOAD) || (state_q == ST_HOLD);
        commit    = in_burst && !pend_q && (idle_cnt_q >= ICW'(IDLE_CYC));
        accept    = wr_start_i && !commit &&
                    ((state_q == ST_IDLE) ||
                     ((state_q == ST_LOAD) && (load_cnt_q < LCW'(LOAD_CYC))));
        capture   = wr_end_i && pend_q;
        prog_last = (state_q == ST_PROG) && (prog_cnt_q == PCW'(PROG_CYC - 1));
    end

    // Burst state, page latch, window counters and program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            page_q     <= '0;
            off_q      <= '0;
            pend_q     <= 1'b0;
            load_cnt_q <= '0;
            idle_cnt_q <= '0;
            prog_cnt_q <= '0;
        end else if (accept) begin
            if (state_q == ST_IDLE) page_q <= addr_i[ADDR_W-1:OFF_W];
            off_q      <= addr_i[OFF_W-1:0];
            pend_q     <= 1'b1;
            load_cnt_q <= '0;
            idle_cnt_q <= '0;
            state_q    <= ST_LOAD;
        end else begin
            if (capture) begin
                pend_q     <= 1'b0;
                idle_cnt_q <= '0;
            end else if (idle_cnt_q < ICW'(IDLE_CYC)) begin
                idle_cnt_q <= idle_cnt_q + ICW'(1);
            end
            if (load_cnt_q < LCW'(LOAD_CYC)) load_cnt_q <= load_cnt_q + LCW'(1);
            if (commit) begin
                state_q    <= ST_PROG;
                prog_cnt_q <= '0;
            end else if ((state_q == ST_LOAD) && (load_cnt_q >= LCW'(LOAD_CYC))) begin
                state_q <= ST_HOLD;
            end else if (prog_last) begin
                state_q <= ST_IDLE;
            end else if (state_q == ST_PROG) begin
                prog_cnt_q <= prog_cnt_q + PCW'(1);
            end
        end
    end

    // Drive the buffer and array ports from the sequencer state.
    always_comb begin
        buf_we_o    = capture;
        buf_widx_o  = off_q;
        buf_clr_o   = prog_last;
        buf_ridx_o  = prog_cnt_q[OFF_W-1:0];
        arr_we_o    = (state_q == ST_PROG) && (prog_cnt_q < PCW'(PAGE_BYTES)) && buf_valid_i;
        arr_waddr_o = {page_q, prog_cnt_q[OFF_W-1:0]};
        busy_o      = (state_q != ST_IDLE);
    end

    // R4: a strobe inside an open burst or program phase never moves the page.
    a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) && wr_start_i |=> $stable(page_q));

    // R5: once the load window has run out, the burst leaves the load phase.
    a_r5_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) && (load_cnt_q >= LCW'(LOAD_CYC)) |=> (state_q != ST_LOAD));

    // R6: programming starts only after the full quiet time.
    a_r6_commit_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_PROG) |-> ($past(idle_cnt_q) >= ICW'(IDLE_CYC)));

    // R7: the program phase ends after its fixed length and releases busy.
    a_r7_prog_ends: assert property (@(posedge clk) disable iff (!rst_n)
        prog_last |=> (state_q == ST_IDLE) && !busy_o);

    // R8: the buffer takes no byte while the page is being programmed.
    a_r8_no_load_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |-> !buf_we_o);

endmodule

// File: rtl/eeprom_page_writer.sv
// Module: top of the parallel EEPROM page-write sequencer.
// Ties together the strobe detector, the burst sequencer, the page buffer and the
// memory array.
// Assumes synchronous enables, strobes of at least one cycle, and
// LOAD_CYC < IDLE_CYC, PROG_CYC >= PAGE_BYTES.
module eeprom_page_writer #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64,
    parameter int LOAD_CYC   = 30,
    parameter int IDLE_CYC   = 100,
    parameter int PROG_CYC   = 200,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              busy
);

    logic              wr_start;
    logic              wr_end;
    logic              rd_en;
    logic              buf_we;
    logic [OFF_W-1:0]  buf_widx;
    logic              buf_clr;
    logic [OFF_W-1:0]  buf_ridx;
    logic [DATA_W-1:0] buf_rdata;
    logic              buf_rvalid;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;

    eepw_strobe u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .wr_start_o (wr_start),
        .wr_end_o   (wr_end),
        .rd_en_o    (rd_en)
    );

    eepw_ctrl #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .LOAD_CYC   (LOAD_CYC),
        .IDLE_CYC   (IDLE_CYC),
        .PROG_CYC   (PROG_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_start_i  (wr_start),
        .wr_end_i    (wr_end),
        .addr_i      (addr),
        .buf_valid_i (buf_rvalid),
        .buf_we_o    (buf_we),
        .buf_widx_o  (buf_widx),
        .buf_clr_o   (buf_clr),
        .buf_ridx_o  (buf_ridx),
        .arr_we_o    (arr_we),
        .arr_waddr_o (arr_waddr),
        .busy_o      (busy)
    );

    eepw_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (buf_we),
        .wr_idx_i   (buf_widx),
        .wr_data_i  (din),
        .clr_i      (buf_clr),
        .rd_idx_i   (buf_ridx),
        .rd_data_o  (buf_rdata),
        .rd_valid_o (buf_rvalid)
    );

    eepw_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (arr_we),
        .waddr_i (arr_waddr),
        .wdata_i (buf_rdata),
        .re_i    (rd_en),
        .raddr_i (addr),
        .rdata_o (dout)
    );

endmodule

// File: tb/eeprom_page_writer_bench.sv
// Bench: self-checking stimulus for the page-write sequencer, run with default parameters.
module eeprom_page_writer_bench;

    localparam int ADDR_W   = 11;
    localparam int IDLE_CYC = 100;
    localparam int PROG_CYC = 200;
    localparam int NVEC     = 8;
    // Vector table: {offset[13:8], data[7:0]}, written as one burst into page 3.
    localparam logic [13:0] VEC [NVEC] = '{
        {6'd5,  8'h3C}, {6'd9,  8'h11}, {6'd20, 8'hA7}, {6'd9,  8'h5E},
        {6'd63, 8'hF0}, {6'd0,  8'h01}, {6'd33, 8'h99}, {6'd40, 8'h6B}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ce_n, we_n, oe_n;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        din;
    logic [7:0]        dout;
    logic              busy;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] model [1 << ADDR_W];

    eeprom_page_writer u_eeprom_page_writer (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .busy(busy)
    );

    always #2 clk = ~clk;

    function automatic logic [ADDR_W-1:0] ad(input int pg, input int off);
        return ADDR_W'(pg * 64 + off);
    endfunction

    function automatic logic [7:0] pat(input int pg, input int off);
        return 8'(pg * 37 + off * 3 + 1);
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // One write strobe: two cycles with both enables low, data held through the end.
    task automatic strobe(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic oe);
        @(negedge clk); addr = a; din = d; oe_n = oe; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic read_chk(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk); check(32'(dout), 32'(exp), req);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic fill_page(input int pg);
        for (int i = 0; i < 64; i++) begin
            strobe(ad(pg, i), pat(pg, i), 1'b1);
            model[ad(pg, i)] = pat(pg, i);
        end
        wait_idle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int n;
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        @(negedge clk);
        check(32'(busy), 0, "R1 busy after reset");
        check(32'(dout), 0, "R1 dout after reset");

        // R6: full pages are written completely.
        fill_page(2); fill_page(3); fill_page(6);
        for (int i = 0; i < 64; i++) read_chk(ad(3, i), model[ad(3, i)], "R6 full page");
        read_chk(ad(2, 63), pat(2, 63), "R6 full page end");

        // Vector table walk (R6 partial page, R9 repeated offset).
        for (int i = 0; i < NVEC; i++) begin
            strobe(ad(3, int'(VEC[i][13:8])), VEC[i][7:0], 1'b1);
            model[ad(3, int'(VEC[i][13:8]))] = VEC[i][7:0];
        end
        wait_idle();
        for (int i = 0; i < 64; i++) read_chk(ad(3, i), model[ad(3, i)], "R6 R9 partial page");
        read_chk(ad(3, 9), 8'h5E, "R9 last write wins");

        // R4: second byte with another page in its address stays in the first page.
        strobe(ad(2, 1), 8'hC1, 1'b1);
        strobe(ad(6, 2), 8'hC2, 1'b1);
        wait_idle();
        read_chk(ad(2, 1), 8'hC1, "R4 first byte");
        read_chk(ad(2, 2), 8'hC2, "R4 second byte in first page");
        read_chk(ad(6, 2), pat(6, 2), "R4 other page untouched");

        // R5: a strobe after the load window is dropped.
        strobe(ad(2, 10), 8'hA5, 1'b1);
        repeat (40) @(negedge clk);
        strobe(ad(6, 11), 8'h5A, 1'b1);
        wait_idle();
        read_chk(ad(2, 10), 8'hA5, "R5 in-window byte");
        read_chk(ad(6, 11), pat(6, 11), "R5 late byte dropped");
        read_chk(ad(2, 11), pat(2, 11), "R5 late byte not in old page");

        // R11: after busy falls, the same write opens a new burst.
        strobe(ad(6, 11), 8'h5A, 1'b1);
        wait_idle();
        read_chk(ad(6, 11), 8'h5A, "R11 new burst page");

        // R8: strobe during the program phase is ignored.
        strobe(ad(2, 20), 8'h77, 1'b1);
        repeat (IDLE_CYC + 20) @(negedge clk);
        check(32'(busy), 1, "R8 still programming");
        strobe(ad(2, 21), 8'h88, 1'b1);
        wait_idle();
        read_chk(ad(2, 20), 8'h77, "R8 burst byte");
        read_chk(ad(2, 21), pat(2, 21), "R8 strobe ignored");

        // R2: output enable low turns the cycle into a non-write.
        strobe(ad(2, 30), 8'hEE, 1'b0);
        @(negedge clk);
        check(32'(busy), 0, "R2 no busy with oe low");
        repeat (IDLE_CYC + PROG_CYC) @(negedge clk);
        read_chk(ad(2, 30), pat(2, 30), "R2 no write with oe low");

        // R3: address from strobe start, data from strobe end.
        @(negedge clk); addr = ad(6, 40); din = 8'h01; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); addr = ad(6, 41); din = 8'h99;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        wait_idle();
        read_chk(ad(6, 40), 8'h99, "R3 end data at start address");
        read_chk(ad(6, 41), pat(6, 41), "R3 later address unused");

        // R7: busy rises the cycle after the start and spans quiet time plus program.
        @(negedge clk); addr = ad(2, 50); din = 8'h42; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); check(32'(busy), 1, "R7 busy rises");
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        n = 3;
        forever begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
        check(32'(n >= IDLE_CYC + PROG_CYC && n <= IDLE_CYC + PROG_CYC + 4), 1, "R7 busy length");
        read_chk(ad(2, 50), 8'h42, "R7 byte programmed");

        // R10: no read, no data.
        @(negedge clk);
        check(32'(dout), 0, "R10 dout zero without read");

        summary();
    end

endmodule